// File: doc/BRIEF.md
# Frame Aligning Demultiplexer and Destuffer

This block receives a bit-interleaved aggregate stream, one bit per clock, that carries four tributaries inside fixed-length frames. It hunts bit by bit for the frame alignment word, confirms the frame phase over several frames, and then splits the payload that follows each word into four tributary streams in strict rotation.

Each tributary has three control bits per frame. A majority vote on those bits tells whether that tributary's justifiable bit carries data or is a stuff bit to be dropped. Each tributary comes out as a data bit with a valid strobe. The strobes are irregular because of the frame overhead and the dropped stuff bits. Smoothing that timing is left to a downstream phase-locked loop. An in-frame flag reports whether the block holds frame alignment.

Frame layout with the default parameters: 56 bits per frame. Bits 0 to 7 hold the alignment word, sent MSB first. Payload bit k (k = 0 to 47) goes to tributary k mod 4 and fills that tributary's slot k div 4. Slots 0 to 2 are the control bits, slot 3 is the justifiable bit, and slots 4 to 11 are data.

Top module: `pdh_frame_demux`

## Requirements
- R1: After reset, in_frame is 0 and no trib_vld bit is set.
- R2: The alignment word is 8'b11100100 (MSB first). When it is found at the same phase in 3 consecutive 56-bit frames, in_frame rises at the third match, and the payload of that third frame is delivered.
- R3: While frame phase is being confirmed, a missing word at the expected position abandons the candidate phase and restarts the bit-by-bit search. Lock then needs 3 new consecutive matches.
- R4: While locked, in_frame drops after 4 consecutive frames without the word at the expected position. A good word in between resets the miss count, so 3 misses, then a hit, then 3 more misses keep lock.
- R5: No trib_vld strobe is raised while in_frame is 0. The payload of frames received out of lock is discarded.
- R6: Payload bit k after the word belongs to tributary k mod 4, in slot k div 4. Slots 0 to 2 are control bits, slot 3 is justifiable, and slots 4 and up are data. Each tributary's delivered bits equal its sent data bits, in order.
- R7: When at least 2 of a tributary's 3 control bits are 1, its justifiable bit is dropped. Otherwise it is delivered as data between the control bits and the data slots. A single corrupted control bit does not change the decision.
- R8: At most one trib_vld bit is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one aggregate bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Aggregate serial bit |
| trib_bit | output | 4 | Recovered data bit per tributary |
| trib_vld | output | 4 | Strobe marking trib_bit valid per tributary |
| in_frame | output | 1 | 1 while frame alignment is held |

## Verification
The stream starts with zero fill and word-aligned frames, so the bench can tell where lock is first reached. Sequences of missing words are arranged to separate the loss threshold from a miss count that a good word has reset. A single miss inserted during confirmation shows that the confirmation count restarts. Control words of 000, 111 and each single-error pattern are mixed across tributaries, so the scoreboard's per-tributary queues expose a wrong vote, a wrong rotation order or a lost data bit.

// File: rtl/pdh_frame_demux.sv
module pdh_frame_demux #(
  parameter int FAW_LEN  = 8,
  parameter logic [FAW_LEN-1:0] FAW = 8'b1110_0100,
  parameter int NTRIB    = 4,
  parameter int SLOTS    = 12,
  parameter int LOCK_CNT = 3,
  parameter int LOSS_CNT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  output logic [NTRIB-1:0] trib_bit,
  output logic [NTRIB-1:0] trib_vld,
  output logic             in_frame
);
  localparam int FRAME_BITS = FAW_LEN + NTRIB * SLOTS;
  localparam int POS_W = $clog2(FRAME_BITS);
  localparam int CNT_W = $clog2(LOCK_CNT + LOSS_CNT + 1);
  localparam int CTL_N = 3;
  localparam logic [POS_W-1:0] NT   = POS_W'(NTRIB);
  localparam logic [POS_W-1:0] JUST = POS_W'(CTL_N);

  typedef enum logic [1:0] {HUNT, CONFIRM, LOCKED} st_t;
  st_t state;

  logic [FAW_LEN-1:0] sr;
  logic [POS_W-1:0]   pos;
  logic [CNT_W-1:0]   cnt;
  logic [CTL_N-1:0]   ctl [NTRIB];

  wire [FAW_LEN-1:0] sr_nx   = {sr[FAW_LEN-2:0], din};
  wire               word_ok = (sr_nx == FAW);
  wire               at_chk  = (pos == POS_W'(FAW_LEN - 1));
  wire               payload = (pos >= POS_W'(FAW_LEN));
  wire [POS_W-1:0]   k       = pos - POS_W'(FAW_LEN);
  wire [POS_W-1:0]   tidx    = k % NT;
  wire [POS_W-1:0]   slot    = k / NT;
  wire [CTL_N-1:0]   c       = ctl[tidx];
  wire               stuffed = (c[0] & c[1]) | (c[0] & c[2]) | (c[1] & c[2]);
  wire               deliver = payload && (slot > JUST || (slot == JUST && !stuffed));

  assign in_frame = (state == LOCKED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= HUNT;
      pos      <= '0;
      cnt      <= '0;
      sr       <= '0;
      trib_vld <= '0;
      trib_bit <= '0;
      for (int t = 0; t < NTRIB; t++) ctl[t] <= '0;
    end else begin
      sr       <= sr_nx;
      trib_vld <= '0;
      pos      <= (pos == POS_W'(FRAME_BITS - 1)) ? '0 : pos + 1'b1;
      case (state)
        HUNT: if (word_ok) begin
          pos   <= POS_W'(FAW_LEN);
          state <= CONFIRM;
          cnt   <= CNT_W'(1);
        end
        CONFIRM: if (at_chk) begin
          if (!word_ok) begin
            state <= HUNT;
            cnt   <= '0;
          end else if (cnt == CNT_W'(LOCK_CNT - 1)) begin
            state <= LOCKED;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        LOCKED: if (at_chk) begin
          if (word_ok) cnt <= '0;
          else if (cnt == CNT_W'(LOSS_CNT - 1)) begin
            state <= HUNT;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= HUNT;
      endcase
      if (payload && slot < JUST) ctl[tidx][slot[1:0]] <= din;
      if (state == LOCKED && deliver) begin
        trib_vld[tidx] <= 1'b1;
        trib_bit[tidx] <= din;
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trib_vld)); // R8
  AST_NO_STROBE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (trib_vld != '0) |-> in_frame); // R5
  AST_LOCK_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> ($past(word_ok) && $past(cnt) == CNT_W'(LOCK_CNT - 1))); // R2
  AST_LOSS_AFTER_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_frame) |-> (!$past(word_ok) && $past(cnt) == CNT_W'(LOSS_CNT - 1))); // R4
endmodule

// File: tb/tb_pdh_frame_demux.sv
module tb_pdh_frame_demux;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int SL = 12;
  localparam logic [7:0] WORD = 8'b1110_0100;

  logic clk = 0, rst_n = 0, din = 0;
  logic [NT-1:0] trib_bit, trib_vld;
  logic in_frame;
  int total = 0, bad = 0;
  bit started = 0, done = 0;
  bit exp_q [NT][$];

  pdh_frame_demux dut (.clk(clk), .rst_n(rst_n), .din(din),
    .trib_bit(trib_bit), .trib_vld(trib_vld), .in_frame(in_frame));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic got, input logic exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0b expected=%0b", req, got, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    total++;
    if ($countones(trib_vld) > 1) begin
      bad++;
      $display("FAIL R8: trib_vld=%b expected at most one bit", trib_vld);
    end
    for (int t = 0; t < NT; t++) if (trib_vld[t]) begin
      if (exp_q[t].size() == 0) begin
        total++; bad++;
        $display("FAIL R5 R7: trib %0d strobe got=1 expected=0 (nothing pending)", t);
      end else begin
        bit e;
        e = exp_q[t].pop_front();
        chk(trib_bit[t], e, $sformatf("R6 R7 trib %0d", t));
      end
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk) din = b;
  endtask

  task automatic send_frame(input logic [7:0] w, input logic [3*NT-1:0] ctlw, input bit out_exp);
    for (int i = 7; i >= 0; i--) send_bit(w[i]);
    for (int k = 0; k < NT*SL; k++) begin
      int t, s;
      logic [2:0] cw;
      logic b;
      t = k % NT; s = k / NT; cw = ctlw[3*t +: 3];
      if (s < 3) b = cw[s];
      else if (s == 3 && $countones(cw) >= 2) b = out_exp ? 1'($urandom) : 1'b0;
      else begin
        b = out_exp ? 1'($urandom) : 1'b0;
        if (out_exp) exp_q[t].push_back(b);
      end
      send_bit(b);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    chk(in_frame, 1'b0, "R1 in_frame");
    chk(trib_vld == '0, 1'b1, "R1 no strobe");
    started = 1;
    repeat (20) send_bit(1'b0);
    send_frame(WORD, '0, 0); chk(in_frame, 1'b0, "R2 one match");
    send_frame(WORD, '0, 0); chk(in_frame, 1'b0, "R2 two matches");
    send_frame(WORD, '0, 1); chk(in_frame, 1'b1, "R2 lock at third");
    send_frame(WORD, {3'b010, 3'b101, 3'b000, 3'b111}, 1);
    send_frame(WORD, {3'b100, 3'b011, 3'b110, 3'b000}, 1);
    send_frame(8'h00, {3'b001, 3'b111, 3'b000, 3'b110}, 1); chk(in_frame, 1'b1, "R4 miss 1");
    send_frame(8'h00, '0, 1); chk(in_frame, 1'b1, "R4 miss 2");
    send_frame(8'h00, '0, 1); chk(in_frame, 1'b1, "R4 miss 3");
    send_frame(WORD, {3'b111, 3'b111, 3'b111, 3'b111}, 1); chk(in_frame, 1'b1, "R4 hit resets count");
    send_frame(8'h00, '0, 1);
    send_frame(8'h00, '0, 1);
    send_frame(8'h00, '0, 1); chk(in_frame, 1'b1, "R4 three after hit");
    send_frame(8'h00, '0, 0); chk(in_frame, 1'b0, "R4 loss at fourth");
    send_frame(WORD, '0, 0); chk(in_frame, 1'b0, "R3 candidate");
    send_frame(8'h00, '0, 0); chk(in_frame, 1'b0, "R3 miss while confirming");
    send_frame(WORD, '0, 0); chk(in_frame, 1'b0, "R3 restart 1");
    send_frame(WORD, '0, 0); chk(in_frame, 1'b0, "R3 restart 2");
    send_frame(WORD, {3'b011, 3'b000, 3'b101, 3'b001}, 1); chk(in_frame, 1'b1, "R3 relock");
    send_frame(WORD, {3'b000, 3'b110, 3'b010, 3'b111}, 1);
    repeat (4) send_bit(1'b0);
    for (int t = 0; t < NT; t++)
      chk(exp_q[t].size() == 0, 1'b1, $sformatf("R6 trib %0d all bits delivered", t));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule